// File: doc/BRIEF.md
# Write-Merging Line Store Buffer

This block sits between a slave write port and a downstream memory write port. It gathers word writes into three line-sized slots of 32 bytes each. A write that lands on a line already held is merged into that slot's data and byte mask. Each slot is sent downstream as a single beat that carries the line address, the 256-bit data and a 32-bit byte strobe.

A slot is drained when any of these conditions holds:
- the line holds device-type data;
- every byte of the line has been written;
- all three slots are in use, and this slot is the one written least recently;
- a read hits the line;
- the slot has sat unwritten for 256 cycles;
- the whole buffer is being flushed.

A locked or strongly ordered access is stalled until the buffer is empty. Any access to the configuration space is accepted at once and flushes every slot. A write to configuration offset 0x730 starts a sync. Bit 0 of that register reads 1 until no slot holds data.

Two state machines control the block.

The drain engine has two states:
- `D_IDLE`: when any slot requests a drain, it takes the **select** transition to `D_SEND`.
- `D_SEND`: it drives `mem_valid` for the chosen slot. On `mem_ready` it takes the **release** transition back to `D_IDLE`, which frees the slot.

The flush controller has three states:
- `FL_IDLE`: a sync write takes **sync start** to `FL_SYNC`. Any other configuration access takes **flush start** to `FL_DRAIN`.
- `FL_DRAIN`: a sync write takes **sync start** to `FL_SYNC`. Otherwise, once no slot is valid, **flush done** returns it to `FL_IDLE`.
- `FL_SYNC`: once no slot is valid, **sync done** returns it to `FL_IDLE`.

While the controller is in `FL_DRAIN` or `FL_SYNC`, every valid slot requests a drain.

Top module: `store_merge_buffer`

## Requirements
- R1: Writes to the same 32-byte line are merged into one slot. The drain carries the line-aligned address and a byte strobe that is the OR of all merged word strobes, where word w, strobe bit k maps to strobe bit 4*w+k. It carries each written byte's latest data.
- R2: A slot whose 32 strobe bits are all set is drained without any other trigger. `mem_valid` rises on the second cycle after the completing write is accepted.
- R3: A write with `req_device` set is drained at once. `mem_valid` is low in the first cycle after acceptance and high in the second.
- R4: A strongly ordered or locked access (read or write) is held with `req_ready` low until no slot holds data, and the held slots are drained meanwhile.
- R5: When all three slots hold data, the slot written least recently is drained first.
- R6: A read whose line matches a held slot is stalled, that slot is drained, and then the read is accepted.
- R7: Any configuration-space access is accepted without stall and causes every held slot to be drained.
- R8: A slot is drained once 256 cycles have passed since its last write. A merging write restarts that count.
- R9: A write to configuration offset 0x730 starts a sync. A read of that offset returns bit 0 = 1 while the sync runs and 0 once no slot holds data.
- R10: Only one slot drains at a time. While `mem_valid` is high and `mem_ready` is low, `mem_valid`, address and strobe stay unchanged.
- R11: Among slots requesting a drain together, the one with the longest time since its last write goes first; ties go to the lowest slot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request may proceed this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Write word |
| req_wstrb | input | 4 | Byte enables of the write word |
| req_device | input | 1 | Device-type memory attribute |
| req_strong | input | 1 | Strongly ordered attribute |
| req_locked | input | 1 | Locked transaction |
| req_cfg | input | 1 | Access targets the configuration space |
| cfg_rdata | output | 32 | Read data for a configuration read; bit 0 is sync busy at offset 0x730 |
| mem_valid | output | 1 | Downstream line write valid |
| mem_ready | input | 1 | Downstream ready |
| mem_addr | output | 32 | Line-aligned address of the drained slot |
| mem_data | output | 256 | Line data of the drained slot |
| mem_strb | output | 32 | Byte strobe of the drained slot |

## Verification
A device write or a line-completing write shows `mem_valid` on the second cycle after acceptance. An age timeout shows it 256 cycles after the slot's last write. A sync busy read returns 1 from the cycle after the sync write until the cycle after the last drain handshake.

The bench samples outputs two time units after each falling edge. It tests each timing window on both sides: before the window it confirms `mem_valid` is low and the drain count has not moved, and after the window it confirms the drain occurred. A scoreboard queue holds the expected address, strobe and data of every drain in the required order, and a monitor compares each handshake against the head of that queue.

// File: rtl/sb_pkg.sv
package sb_pkg;

    typedef enum logic [0:0] {
        D_IDLE,
        D_SEND
    } drain_state_e;

    typedef enum logic [1:0] {
        FL_IDLE,
        FL_DRAIN,
        FL_SYNC
    } flush_state_e;

endpackage

// File: rtl/sb_slot.sv
module sb_slot #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int WORD_BYTES = 4,
    parameter int AGE_LIMIT  = 256,
    localparam int LINE_W = LINE_BYTES * 8,
    localparam int WORD_W = WORD_BYTES * 8,
    localparam int WORDS  = LINE_BYTES / WORD_BYTES,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int WIDX_W = $clog2(WORDS),
    localparam int TAG_W  = ADDR_W - OFF_W,
    localparam int AGE_W  = $clog2(AGE_LIMIT)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_alloc,
    input  logic [TAG_W-1:0]      wr_tag,
    input  logic [WIDX_W-1:0]     wr_widx,
    input  logic [WORD_W-1:0]     wr_data,
    input  logic [WORD_BYTES-1:0] wr_strb,
    input  logic                  wr_dev,
    input  logic                  release_i,
    output logic                  valid_o,
    output logic [TAG_W-1:0]      tag_o,
    output logic [LINE_W-1:0]     data_o,
    output logic [LINE_BYTES-1:0] mask_o,
    output logic [AGE_W-1:0]      age_o,
    output logic                  dev_o,
    output logic                  full_o,
    output logic                  timeout_o
);

    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_LIMIT - 1);

    logic [LINE_BYTES-1:0] new_mask;
    logic [LINE_W-1:0]     wr_line;

    assign new_mask = {{(LINE_BYTES-WORD_BYTES){1'b0}}, wr_strb} << (wr_widx * WORD_BYTES);
    assign wr_line  = {WORDS{wr_data}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            tag_o   <= '0;
            mask_o  <= '0;
            age_o   <= '0;
            dev_o   <= 1'b0;
        end else if (release_i) begin
            valid_o <= 1'b0;
            mask_o  <= '0;
            age_o   <= '0;
            dev_o   <= 1'b0;
        end else if (wr_en) begin
            valid_o <= 1'b1;
            age_o   <= '0;
            if (wr_alloc) begin
                tag_o  <= wr_tag;
                mask_o <= new_mask;
                dev_o  <= wr_dev;
            end else begin
                mask_o <= mask_o | new_mask;
                dev_o  <= dev_o | wr_dev;
            end
        end else if (valid_o && (age_o != AGE_MAX)) begin
            age_o <= age_o + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            for (int b = 0; b < LINE_BYTES; b++) begin
                if (new_mask[b]) data_o[b*8 +: 8] <= wr_line[b*8 +: 8];
            end
        end
    end

    assign full_o    = &mask_o;
    assign timeout_o = valid_o && (age_o == AGE_MAX);

endmodule

// File: rtl/sb_drain_arb.sv
module sb_drain_arb
    import sb_pkg::*;
#(
    parameter int NSLOTS = 3,
    parameter int AGE_W  = 8,
    localparam int SEL_W = (NSLOTS > 1) ? $clog2(NSLOTS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NSLOTS-1:0]       drain_req,
    input  logic [NSLOTS*AGE_W-1:0] ages,
    input  logic                    mem_ready,
    output logic                    mem_valid,
    output logic [SEL_W-1:0]        sel_o,
    output logic [NSLOTS-1:0]       release_o
);

    drain_state_e st, nxt;
    logic             found;
    logic [SEL_W-1:0] pick;
    logic [AGE_W-1:0] pick_age;

    // oldest requester first, lowest index on equal age (R11)
    always_comb begin
        found    = 1'b0;
        pick     = '0;
        pick_age = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (drain_req[i] && (!found || (ages[i*AGE_W +: AGE_W] > pick_age))) begin
                found    = 1'b1;
                pick     = SEL_W'(i);
                pick_age = ages[i*AGE_W +: AGE_W];
            end
        end
    end

    always_comb begin
        nxt = st;
        unique case (st)
            D_IDLE: if (found)     nxt = D_SEND;
            D_SEND: if (mem_ready) nxt = D_IDLE;
            default:               nxt = D_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= D_IDLE;
        else        st <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     sel_o <= '0;
        else if (st == D_IDLE && found) sel_o <= pick;
    end

    always_comb begin
        mem_valid = 1'b0;
        release_o = '0;
        unique case (st)
            D_IDLE: ;
            D_SEND: begin
                mem_valid = 1'b1;
                if (mem_ready) release_o = NSLOTS'(1) << sel_o;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sb_flush_ctrl.sv
module sb_flush_ctrl
    import sb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_hit,
    input  logic sync_hit,
    input  logic any_valid,
    output logic flush_o,
    output logic busy_o
);

    flush_state_e st, nxt;

    always_comb begin
        nxt = st;
        unique case (st)
            FL_IDLE: begin
                if (sync_hit)     nxt = FL_SYNC;
                else if (cfg_hit) nxt = FL_DRAIN;
            end
            FL_DRAIN: begin
                if (sync_hit)                   nxt = FL_SYNC;
                else if (!any_valid && !cfg_hit) nxt = FL_IDLE;
            end
            FL_SYNC: begin
                if (!any_valid && !sync_hit) nxt = FL_IDLE;
            end
            default: nxt = FL_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FL_IDLE;
        else        st <= nxt;
    end

    always_comb begin
        flush_o = 1'b0;
        busy_o  = 1'b0;
        unique case (st)
            FL_IDLE:  ;
            FL_DRAIN: flush_o = 1'b1;
            FL_SYNC: begin
                flush_o = 1'b1;
                busy_o  = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/store_merge_buffer.sv
module store_merge_buffer #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4,
    parameter int LINE_BYTES = 32,
    parameter int NSLOTS     = 3,
    parameter int AGE_LIMIT  = 256,
    parameter int CFG_OFF_W  = 12,
    parameter logic [CFG_OFF_W-1:0] SYNC_OFF = 'h730,
    localparam int WORD_W = WORD_BYTES * 8,
    localparam int LINE_W = LINE_BYTES * 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic [WORD_BYTES-1:0] req_wstrb,
    input  logic                  req_device,
    input  logic                  req_strong,
    input  logic                  req_locked,
    input  logic                  req_cfg,
    output logic [WORD_W-1:0]     cfg_rdata,
    output logic                  mem_valid,
    input  logic                  mem_ready,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic [LINE_W-1:0]     mem_data,
    output logic [LINE_BYTES-1:0] mem_strb
);

    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int BOFF_W = $clog2(WORD_BYTES);
    localparam int WIDX_W = OFF_W - BOFF_W;
    localparam int TAG_W  = ADDR_W - OFF_W;
    localparam int AGE_W  = $clog2(AGE_LIMIT);
    localparam int SEL_W  = (NSLOTS > 1) ? $clog2(NSLOTS) : 1;

    logic [NSLOTS-1:0]       slot_valid, slot_full, slot_dev, slot_tmo;
    logic [NSLOTS-1:0]       wr_en, release_v, drain_req, hit, read_haz;
    logic [TAG_W-1:0]        slot_tag  [NSLOTS];
    logic [LINE_W-1:0]       slot_data [NSLOTS];
    logic [LINE_BYTES-1:0]   slot_mask [NSLOTS];
    logic [NSLOTS*AGE_W-1:0] age_flat;

    logic [TAG_W-1:0]  req_tag;
    logic [WIDX_W-1:0] req_widx;
    logic              hit_any, free_any, any_valid, all_valid;
    logic [SEL_W-1:0]  hit_idx, free_idx, lru_idx, sel;
    logic [AGE_W-1:0]  lru_age;
    logic              is_mem, ordered, sync_sel, wr_go;
    logic              cfg_hit, sync_hit, flush_cfg, sync_busy, flush_all;
    logic              sig_unused;

    assign req_tag    = req_addr[ADDR_W-1:OFF_W];
    assign req_widx   = req_addr[OFF_W-1:BOFF_W];
    assign sig_unused = ^req_addr[BOFF_W-1:0];

    assign any_valid = |slot_valid;
    assign all_valid = &slot_valid;
    assign hit_any   = |hit;
    assign free_any  = ~all_valid;

    assign is_mem   = req_valid && !req_cfg && !req_strong && !req_locked;
    assign ordered  = req_valid && !req_cfg && (req_strong || req_locked);
    assign sync_sel = (req_addr[CFG_OFF_W-1:0] == SYNC_OFF);
    assign cfg_hit  = req_valid && req_cfg && !(req_write && sync_sel);
    assign sync_hit = req_valid && req_cfg && req_write && sync_sel;

    always_comb begin
        hit_idx  = '0;
        free_idx = '0;
        for (int i = NSLOTS - 1; i >= 0; i--) begin
            hit[i] = slot_valid[i] && (slot_tag[i] == req_tag);
            if (hit[i])         hit_idx  = SEL_W'(i);
            if (!slot_valid[i]) free_idx = SEL_W'(i);
        end
    end

    always_comb begin
        lru_idx = '0;
        lru_age = '0;
        for (int i = 0; i < NSLOTS; i++) begin
            if (age_flat[i*AGE_W +: AGE_W] > lru_age) begin
                lru_idx = SEL_W'(i);
                lru_age = age_flat[i*AGE_W +: AGE_W];
            end
        end
    end

    always_comb begin
        req_ready = 1'b0;
        if (req_cfg)                       req_ready = 1'b1;
        else if (req_strong || req_locked) req_ready = !any_valid;
        else if (!req_write)               req_ready = !hit_any;
        else if (hit_any)                  req_ready = !(mem_valid && (sel == hit_idx));
        else                               req_ready = free_any;
    end

    assign wr_go     = is_mem && req_write && req_ready;
    assign flush_all = flush_cfg || ordered;

    genvar g;
    generate
        for (g = 0; g < NSLOTS; g++) begin : g_slot
            assign wr_en[g]     = wr_go && (hit_any ? (hit_idx == SEL_W'(g)) : (free_idx == SEL_W'(g)));
            assign read_haz[g]  = is_mem && !req_write && hit[g];
            assign drain_req[g] = slot_valid[g] && (slot_dev[g] || slot_full[g] || slot_tmo[g] ||
                                  read_haz[g] || flush_all || (all_valid && (lru_idx == SEL_W'(g))));

            sb_slot #(
                .ADDR_W     (ADDR_W),
                .LINE_BYTES (LINE_BYTES),
                .WORD_BYTES (WORD_BYTES),
                .AGE_LIMIT  (AGE_LIMIT)
            ) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_en[g]),
                .wr_alloc  (!hit_any),
                .wr_tag    (req_tag),
                .wr_widx   (req_widx),
                .wr_data   (req_wdata),
                .wr_strb   (req_wstrb),
                .wr_dev    (req_device),
                .release_i (release_v[g]),
                .valid_o   (slot_valid[g]),
                .tag_o     (slot_tag[g]),
                .data_o    (slot_data[g]),
                .mask_o    (slot_mask[g]),
                .age_o     (age_flat[g*AGE_W +: AGE_W]),
                .dev_o     (slot_dev[g]),
                .full_o    (slot_full[g]),
                .timeout_o (slot_tmo[g])
            );
        end
    endgenerate

    sb_drain_arb #(
        .NSLOTS (NSLOTS),
        .AGE_W  (AGE_W)
    ) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .drain_req (drain_req),
        .ages      (age_flat),
        .mem_ready (mem_ready),
        .mem_valid (mem_valid),
        .sel_o     (sel),
        .release_o (release_v)
    );

    sb_flush_ctrl u_flush (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_hit   (cfg_hit),
        .sync_hit  (sync_hit),
        .any_valid (any_valid),
        .flush_o   (flush_cfg),
        .busy_o    (sync_busy)
    );

    assign mem_addr  = {slot_tag[sel], {OFF_W{1'b0}}};
    assign mem_data  = slot_data[sel];
    assign mem_strb  = slot_mask[sel];
    assign cfg_rdata = (req_cfg && sync_sel) ? {{(WORD_W-1){1'b0}}, sync_busy} : '0;

endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int NSLOTS     = 3,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  req_valid,
    input logic                  req_ready,
    input logic                  req_cfg,
    input logic                  req_strong,
    input logic                  req_locked,
    input logic                  mem_valid,
    input logic                  mem_ready,
    input logic [ADDR_W-1:0]     mem_addr,
    input logic [LINE_BYTES-1:0] mem_strb,
    input logic [NSLOTS-1:0]     slot_valid,
    input logic [NSLOTS-1:0]     slot_full,
    input logic                  sync_busy
);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_strb));

    assert_drain_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (slot_valid != '0));

    assert_strb_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_valid |-> (mem_strb != '0));

    assert_full_drain_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_full != '0) && !mem_valid |=> mem_valid);

    assert_ordered_empty_R4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_cfg && (req_strong || req_locked) && req_ready |-> (slot_valid == '0));

    assert_sync_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sync_busy) |-> ($past(slot_valid) == '0));

endmodule

bind store_merge_buffer sb_checker #(
    .NSLOTS     (NSLOTS),
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cfg    (req_cfg),
    .req_strong (req_strong),
    .req_locked (req_locked),
    .mem_valid  (mem_valid),
    .mem_ready  (mem_ready),
    .mem_addr   (mem_addr),
    .mem_strb   (mem_strb),
    .slot_valid (slot_valid),
    .slot_full  (slot_full),
    .sync_busy  (sync_busy)
);

// File: tb/tb_store_merge_buffer.sv
module tb_store_merge_buffer;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic         req_valid = 1'b0, req_write = 1'b0, req_device = 1'b0;
    logic         req_strong = 1'b0, req_locked = 1'b0, req_cfg = 1'b0;
    logic [31:0]  req_addr = '0, req_wdata = '0;
    logic [3:0]   req_wstrb = '0;
    logic         req_ready, mem_valid;
    logic         mem_ready = 1'b1;
    logic [31:0]  cfg_rdata, mem_addr, mem_strb;
    logic [255:0] mem_data;

    int n_checks = 0, n_fail = 0, n_drain = 0;
    bit finished = 1'b0;

    logic [31:0]  q_addr[$];
    logic [31:0]  q_strb[$];
    logic [255:0] q_data[$];

    logic [31:0] rd;
    int          st;

    store_merge_buffer dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_wstrb(req_wstrb), .req_device(req_device), .req_strong(req_strong),
        .req_locked(req_locked), .req_cfg(req_cfg), .cfg_rdata(cfg_rdata),
        .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
        .mem_data(mem_data), .mem_strb(mem_strb)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send(input bit wr, input logic [31:0] a, input logic [31:0] d,
                        input logic [3:0] s, input bit dev, input bit so, input bit lk,
                        input bit cfg, output logic [31:0] rdat, output int stalls);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_wstrb = s;
        req_device = dev; req_strong = so; req_locked = lk; req_cfg = cfg;
        stalls = 0;
        #1;
        while (!req_ready) begin
            @(negedge clk); #1;
            stalls++;
        end
        rdat = cfg_rdata;
        @(posedge clk); #1;
        req_valid = 1'b0; req_write = 1'b0; req_device = 1'b0;
        req_strong = 1'b0; req_locked = 1'b0; req_cfg = 1'b0;
    endtask

    task automatic wr_mem(input logic [31:0] a, input logic [31:0] d, input logic [3:0] s);
        send(1'b1, a, d, s, 1'b0, 1'b0, 1'b0, 1'b0, rd, st);
    endtask

    task automatic expect_drain(input logic [31:0] a, input logic [31:0] sb, input logic [255:0] d);
        q_addr.push_back(a);
        q_strb.push_back(sb);
        q_data.push_back(d);
    endtask

    function automatic logic [255:0] wline(input int w, input logic [31:0] d);
        logic [255:0] l = '0;
        l[w*32 +: 32] = d;
        return l;
    endfunction

    function automatic logic [31:0] wstb(input int w, input logic [3:0] s);
        return 32'(s) << (w * 4);
    endfunction

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: compare every downstream handshake with the scoreboard head (R1, R10)
    initial begin
        logic [31:0]  ea, es;
        logic [255:0] ed, bm;
        forever begin
            @(negedge clk); #2;
            if (rst_n && mem_valid && mem_ready) begin
                n_drain++;
                n_checks++;
                if (q_addr.size() == 0) begin
                    n_fail++;
                    $display("FAIL R10: unexpected drain actual addr %h expected none", mem_addr);
                end else begin
                    ea = q_addr.pop_front();
                    es = q_strb.pop_front();
                    ed = q_data.pop_front();
                    bm = '0;
                    for (int b = 0; b < 32; b++) if (es[b]) bm[b*8 +: 8] = 8'hFF;
                    if (mem_addr !== ea || mem_strb !== es || ((mem_data ^ ed) & bm) != '0) begin
                        n_fail++;
                        $display("FAIL R1: drain actual addr %h strb %h data %h expected addr %h strb %h data %h",
                                 mem_addr, mem_strb, mem_data & bm, ea, es, ed);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int base, sync_pos;
        logic [255:0] ld;

        idle(3);
        rst_n = 1'b1;
        idle(1); #2;
        check("reset mem_valid", mem_valid, 0);
        send(1'b0, 32'h730, 0, 0, 0, 0, 0, 1'b1, rd, st);
        check("R9 reset sync busy", rd[0], 0);

        // R1/R2: eight word writes complete line 0x100
        ld = '0;
        for (int w = 0; w < 8; w++) ld |= wline(w, 32'hA000_0000 + w);
        expect_drain(32'h100, 32'hFFFF_FFFF, ld);
        for (int w = 0; w < 7; w++) wr_mem(32'h100 + w*4, 32'hA000_0000 + w, 4'hF);
        idle(3); #2;
        check("R2 no drain before line full", n_drain, 0);
        wr_mem(32'h11C, 32'hA000_0007, 4'hF);
        @(negedge clk); #2;
        check("R2 mem_valid first cycle", mem_valid, 0);
        @(negedge clk); #2;
        check("R2 mem_valid second cycle", mem_valid, 1);
        idle(3);

        // R3: device write drains immediately
        expect_drain(32'h200, wstb(3, 4'b0110), wline(3, 32'hB0B0_0003));
        send(1'b1, 32'h20C, 32'hB0B0_0003, 4'b0110, 1'b1, 0, 0, 0, rd, st);
        @(negedge clk); #2;
        check("R3 mem_valid first cycle", mem_valid, 0);
        @(negedge clk); #2;
        check("R3 mem_valid second cycle", mem_valid, 1);
        idle(3);

        // R4: strongly ordered read waits for held line
        base = n_drain;
        expect_drain(32'h300, wstb(0, 4'hF), wline(0, 32'hC000_0000));
        wr_mem(32'h300, 32'hC000_0000, 4'hF);
        send(1'b0, 32'h9000, 0, 0, 0, 1'b1, 0, 0, rd, st);
        check("R4 strong read stalled", st > 0, 1);
        check("R4 drained before strong read", n_drain, base + 1);

        // R4: locked write waits for held line
        base = n_drain;
        expect_drain(32'h400, wstb(1, 4'h3), wline(1, 32'hD000_0001));
        wr_mem(32'h404, 32'hD000_0001, 4'h3);
        send(1'b1, 32'h9100, 32'h1, 4'hF, 0, 0, 1'b1, 0, rd, st);
        check("R4 locked write stalled", st > 0, 1);
        check("R4 drained before locked write", n_drain, base + 1);
        idle(3);

        // R5: three lines held, least recently written drains
        base = n_drain;
        expect_drain(32'h500, wstb(0, 4'hF), wline(0, 32'hE000_0000));
        wr_mem(32'h500, 32'hE000_0000, 4'hF);
        wr_mem(32'h520, 32'hE100_0000, 4'hF);
        wr_mem(32'h540, 32'hE200_0000, 4'hF);
        idle(6); #2;
        check("R5 exactly one LRU drain", n_drain, base + 1);

        // R6: read hazard on line 0x540
        expect_drain(32'h540, wstb(0, 4'hF), wline(0, 32'hE200_0000));
        send(1'b0, 32'h548, 0, 0, 0, 0, 0, 0, rd, st);
        check("R6 hazard read stalled", st > 0, 1);
        check("R6 slot drained before read", n_drain, base + 2);

        // R11/R7: 0x600 is older than refreshed 0x520, config flush drains both
        expect_drain(32'h600, wstb(2, 4'hF), wline(2, 32'hF000_0002));
        expect_drain(32'h520, wstb(0, 4'hF) | wstb(1, 4'hC),
                     wline(0, 32'hE100_0000) | wline(1, 32'hE1E1_0000));
        wr_mem(32'h608, 32'hF000_0002, 4'hF);
        wr_mem(32'h524, 32'hE1E1_0000, 4'hC);
        send(1'b1, 32'h100, 32'h0, 4'hF, 0, 0, 0, 1'b1, rd, st);
        check("R7 config access not stalled", st, 0);
        idle(8); #2;
        check("R7 R11 both drained", n_drain, base + 4);

        // R8: age timeout after 256 cycles
        base = n_drain;
        expect_drain(32'h700, wstb(5, 4'hF), wline(5, 32'h7070_0005));
        wr_mem(32'h714, 32'h7070_0005, 4'hF);
        idle(250); #2;
        check("R8 not drained before 256", n_drain, base);
        idle(12); #2;
        check("R8 drained after 256", n_drain, base + 1);

        // R8: merge restarts the age count
        base = n_drain;
        expect_drain(32'h800, wstb(0, 4'hF) | wstb(1, 4'hF),
                     wline(0, 32'h8000_0000) | wline(1, 32'h8000_0001));
        wr_mem(32'h800, 32'h8000_0000, 4'hF);
        idle(200);
        wr_mem(32'h804, 32'h8000_0001, 4'hF);
        idle(200); #2;
        check("R8 merge refreshed age", n_drain, base);
        idle(70); #2;
        check("R8 drained after refreshed age", n_drain, base + 1);

        // R9/R10: sync with downstream stalled
        base = n_drain;
        mem_ready = 1'b0;
        expect_drain(32'hA00, wstb(2, 4'hF), wline(2, 32'h5A5A_0002));
        wr_mem(32'hA08, 32'h5A5A_0002, 4'hF);
        send(1'b1, 32'h730, 32'h0, 4'hF, 0, 0, 0, 1'b1, rd, st);
        send(1'b0, 32'h730, 0, 0, 0, 0, 0, 1'b1, rd, st);
        check("R9 sync busy reads 1", rd[0], 1);
        idle(3); #2;
        check("R10 valid held without ready", mem_valid, 1);
        check("R10 address held without ready", mem_addr, 32'hA00);
        @(negedge clk);
        mem_ready = 1'b1;
        sync_pos = 0;
        for (int p = 0; p < 20; p++) begin
            send(1'b0, 32'h730, 0, 0, 0, 0, 0, 1'b1, rd, st);
            sync_pos = p;
            if (rd[0] == 1'b0) break;
        end
        check("R9 sync busy clears", rd[0], 0);
        check("R9 buffer drained at sync done", n_drain, base + 1);

        idle(20);
        check("R10 all expected drains seen", q_addr.size(), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule